// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block drives the parallel pins of a raw RGB panel from a video timing source. On every pixel clock it takes one 24-bit pixel (red in bits 23:16, green in 15:8, blue in 7:0), horizontal and vertical active flags and the two sync pulses. It can permute the colour channels, cut each channel down to its most significant 5 or 6 bits, and place the result into one of several sparse 24-bit pin layouts. It also produces hsync, vsync, an output-enable strobe and a forwarded copy of the pixel clock.

Each of the three control outputs can be held inactive, and each can be launched on either clock edge. The output-enable can also be inverted, and it can follow either the active region or the sync pulses. The forwarded clock can be inverted. All configuration comes in as static inputs. The pixel data and the rising-launched controls pass through one register stage. A control launched on the falling edge is taken from that same stage half a cycle later, so all outputs stay on the same pixel.

Top module: `rgb_out_fmt`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs settle to `pin_data` = 0, `pin_hs` = 0 and `pin_vs` = 0, and `pin_oe` takes its inactive level, which equals `cfg_oe_inv`.
- R2: Format code 0 drives all 24 data pins low. Code 7 is unused and behaves the same way.
- R3: Format code 1 places red[7:3] at bits 15:11, green[7:2] at bits 10:5 and blue[7:3] at bits 4:0. Bits 23:16 are zero.
- R4: Format code 2 places red[7:3] at bits 20:16, green[7:2] at bits 13:8 and blue[7:3] at bits 4:0. Every other bit is zero.
- R5: Format code 3 places red[7:3] at bits 21:17, green[7:2] at bits 13:8 and blue[7:3] at bits 5:1. Every other bit is zero.
- R6: Format code 4 places red[7:2], green[7:2] and blue[7:2] at bits 17:12, 11:6 and 5:0, with bits 23:18 zero. Format code 5 places them at bits 21:16, 13:8 and 5:0, with every other bit zero.
- R7: Format code 6 passes the 8-bit red, green and blue channels through at bits 23:16, 15:8 and 7:0.
- R8: `cfg_order` fills the (red, green, blue) slots before packing. Code 0 gives (R,G,B), code 1 gives (B,G,R), code 2 gives (G,R,B) and code 3 gives (B,R,G).
- R9: When `h_act` or `v_act` is low, the data pins for that pixel are zero, whatever the output-enable mode.
- R10: Data and the rising-launched controls show a pixel's values after the first rising edge that samples it. A control whose `cfg_fall_sel` bit is set (bit 0 hsync, bit 1 vsync, bit 2 output-enable) changes only at the next falling edge, carrying the same pixel.
- R11: A set bit in `cfg_ctl_off` (bit 0 hsync, bit 1 vsync, bit 2 output-enable) holds that output at its inactive level. For hsync and vsync this is 0; for output-enable it is `cfg_oe_inv`.
- R12: Before `cfg_oe_inv` is applied, output-enable is `h_act & v_act` when `cfg_oe_from_sync` is 0 and `hs_in | vs_in` when it is 1. `cfg_oe_inv` = 1 inverts the result.
- R13: `pin_clk` equals `clk` when `cfg_clk_inv` is 0 and its complement when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Pixel: red 23:16, green 15:8, blue 7:0 |
| h_act | input | 1 | Horizontal active flag |
| v_act | input | 1 | Vertical active flag |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync, active high |
| cfg_fmt | input | 3 | Pin layout code |
| cfg_order | input | 2 | Channel order code |
| cfg_ctl_off | input | 3 | Hold-inactive bits: hsync, vsync, output-enable |
| cfg_fall_sel | input | 3 | Falling-edge launch bits: hsync, vsync, output-enable |
| cfg_oe_inv | input | 1 | Invert output-enable |
| cfg_oe_from_sync | input | 1 | Output-enable follows the syncs instead of the active region |
| cfg_clk_inv | input | 1 | Invert forwarded clock |
| pin_data | output | 24 | Packed pixel data pins |
| pin_hs | output | 1 | Horizontal sync pin |
| pin_vs | output | 1 | Vertical sync pin |
| pin_oe | output | 1 | Output-enable pin |
| pin_clk | output | 1 | Forwarded pixel clock |

## Verification
The hardest case to reach is a control launched on the falling edge. In the half cycle between a rising edge and the following falling edge, a falling-launched signal must still show the previous pixel while its rising-launched neighbour already shows the new one. The bench reaches this by giving hsync and vsync different launch edges, switching both together, and sampling while the clock is high as well as after the falling edge. The bench also sweeps all 256 combinations of the control configuration bits against all 16 patterns of the sync and active inputs.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

    localparam int CH_W  = 8;
    localparam int PIX_W = 3 * CH_W;
    localparam int FMT_W = 3;
    localparam int ORD_W = 2;
    localparam int N_CTL = 3;

    // lane indices for control signals
    localparam int LANE_HS = 0;
    localparam int LANE_VS = 1;
    localparam int LANE_OE = 2;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [FMT_W-1:0] {
        FMT_OFF     = 3'd0,
        FMT_565_LO  = 3'd1,
        FMT_565_SP  = 3'd2,
        FMT_565_SH  = 3'd3,
        FMT_666_LO  = 3'd4,
        FMT_666_SP  = 3'd5,
        FMT_888     = 3'd6,
        FMT_RSVD    = 3'd7
    } fmt_e;

    typedef enum logic [ORD_W-1:0] {
        ORD_RGB = 2'd0,
        ORD_BGR = 2'd1,
        ORD_GRB = 2'd2,
        ORD_BRG = 2'd3
    } ord_e;

    // fill the red/green/blue slots from the input channels
    function automatic rgb_t swizzle(input rgb_t c, input ord_e o);
        rgb_t s;
        unique case (o)
            ORD_RGB: s = '{r: c.r, g: c.g, b: c.b};
            ORD_BGR: s = '{r: c.b, g: c.g, b: c.r};
            ORD_GRB: s = '{r: c.g, g: c.r, b: c.b};
            default: s = '{r: c.b, g: c.r, b: c.g};
        endcase
        return s;
    endfunction

    // truncate to MSBs and place into the pin layout
    function automatic logic [PIX_W-1:0] place(input rgb_t c, input fmt_e f);
        logic [4:0] r5, b5;
        logic [5:0] r6, g6, b6;
        logic [PIX_W-1:0] d;
        r5 = c.r[CH_W-1 -: 5];
        b5 = c.b[CH_W-1 -: 5];
        r6 = c.r[CH_W-1 -: 6];
        g6 = c.g[CH_W-1 -: 6];
        b6 = c.b[CH_W-1 -: 6];
        unique case (f)
            FMT_565_LO: d = {8'b0, r5, g6, b5};
            FMT_565_SP: d = {3'b0, r5, 2'b0, g6, 3'b0, b5};
            FMT_565_SH: d = {2'b0, r5, 3'b0, g6, 2'b0, b5, 1'b0};
            FMT_666_LO: d = {6'b0, r6, g6, b6};
            FMT_666_SP: d = {2'b0, r6, 2'b0, g6, 2'b0, b6};
            FMT_888:    d = {c.r, c.g, c.b};
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rgbfmt_datapath.sv
module rgbfmt_datapath
    import rgbfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix,
    input  logic             act,
    input  logic [FMT_W-1:0] fmt,
    input  logic [ORD_W-1:0] order,
    output logic [PIX_W-1:0] data_q
);

    rgb_t             src;
    rgb_t             slot;
    logic [PIX_W-1:0] packed_d;

    always_comb begin
        src      = rgb_t'(pix);
        slot     = swizzle(src, ord_e'(order));
        packed_d = act ? place(slot, fmt_e'(fmt)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= packed_d;
    end

    AST_FMT_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(fmt) == 3'd0 || $past(fmt) == 3'd7)) |-> data_q == '0); // R2

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(act)) |-> data_q == '0); // R9

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act) && $past(fmt) == 3'd6 && $past(order) == 2'd0)
        |-> data_q == $past(pix)); // R7

endmodule

// File: rtl/rgbfmt_ctl_lane.sv
module rgbfmt_ctl_lane (
    input  logic clk,
    input  logic rst,
    input  logic nxt,
    input  logic idle_lvl,
    input  logic fall_sel,
    output logic pin
);

    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk) begin
        if (rst) rise_q <= idle_lvl;
        else     rise_q <= nxt;
    end

    // half-cycle retime of the same pixel's value
    always_ff @(negedge clk) begin
        if (rst) fall_q <= idle_lvl;
        else     fall_q <= rise_q;
    end

    assign pin = fall_sel ? fall_q : rise_q;

endmodule

// File: rtl/rgb_out_fmt.sv
module rgb_out_fmt
    import rgbfmt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PIX_W-1:0]        pix_in,
    input  logic                    h_act,
    input  logic                    v_act,
    input  logic                    hs_in,
    input  logic                    vs_in,
    input  logic [FMT_W-1:0]        cfg_fmt,
    input  logic [ORD_W-1:0]        cfg_order,
    input  logic [N_CTL-1:0]        cfg_ctl_off,
    input  logic [N_CTL-1:0]        cfg_fall_sel,
    input  logic                    cfg_oe_inv,
    input  logic                    cfg_oe_from_sync,
    input  logic                    cfg_clk_inv,
    output logic [PIX_W-1:0]        pin_data,
    output logic                    pin_hs,
    output logic                    pin_vs,
    output logic                    pin_oe,
    output logic                    pin_clk
);

    logic             active;
    logic             oe_raw;
    logic [N_CTL-1:0] lane_lvl;
    logic [N_CTL-1:0] lane_idle;
    logic [N_CTL-1:0] lane_nxt;
    logic [N_CTL-1:0] lane_pin;

    assign active = h_act & v_act;

    rgbfmt_datapath u_dp (
        .clk    (clk),
        .rst    (rst),
        .pix    (pix_in),
        .act    (active),
        .fmt    (cfg_fmt),
        .order  (cfg_order),
        .data_q (pin_data)
    );

    always_comb begin
        oe_raw             = cfg_oe_from_sync ? (hs_in | vs_in) : active;
        lane_lvl[LANE_HS]  = hs_in;
        lane_lvl[LANE_VS]  = vs_in;
        lane_lvl[LANE_OE]  = oe_raw ^ cfg_oe_inv;
        lane_idle[LANE_HS] = 1'b0;
        lane_idle[LANE_VS] = 1'b0;
        lane_idle[LANE_OE] = cfg_oe_inv;
    end

    for (genvar i = 0; i < N_CTL; i++) begin : g_lane
        assign lane_nxt[i] = cfg_ctl_off[i] ? lane_idle[i] : lane_lvl[i];

        rgbfmt_ctl_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .nxt      (lane_nxt[i]),
            .idle_lvl (lane_idle[i]),
            .fall_sel (cfg_fall_sel[i]),
            .pin      (lane_pin[i])
        );
    end

    assign pin_hs  = lane_pin[LANE_HS];
    assign pin_vs  = lane_pin[LANE_VS];
    assign pin_oe  = lane_pin[LANE_OE];
    assign pin_clk = clk ^ cfg_clk_inv;

    AST_HS_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_ctl_off[0])) |-> !pin_hs); // R11

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_ctl_off[2])) |-> pin_oe == $past(cfg_oe_inv)); // R11

    AST_OE_ACTIVE_MODE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_oe_from_sync) && !$past(cfg_ctl_off[2]))
        |-> pin_oe == (($past(h_act) && $past(v_act)) ^ $past(cfg_oe_inv))); // R12

    AST_VS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_ctl_off[1])) |-> pin_vs == $past(vs_in)); // R10

endmodule

// File: tb/sim_rgb_out_fmt.sv
module sim_rgb_out_fmt;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pix_in = '0;
    logic        h_act = 1'b0, v_act = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic [2:0]  cfg_fmt = '0;
    logic [1:0]  cfg_order = '0;
    logic [2:0]  cfg_ctl_off = '0;
    logic [2:0]  cfg_fall_sel = '0;
    logic        cfg_oe_inv = 1'b0, cfg_oe_from_sync = 1'b0, cfg_clk_inv = 1'b0;
    logic [23:0] pin_data;
    logic        pin_hs, pin_vs, pin_oe, pin_clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_out_fmt u0 (
        .clk(clk), .rst(rst), .pix_in(pix_in), .h_act(h_act), .v_act(v_act),
        .hs_in(hs_in), .vs_in(vs_in), .cfg_fmt(cfg_fmt), .cfg_order(cfg_order),
        .cfg_ctl_off(cfg_ctl_off), .cfg_fall_sel(cfg_fall_sel),
        .cfg_oe_inv(cfg_oe_inv), .cfg_oe_from_sync(cfg_oe_from_sync),
        .cfg_clk_inv(cfg_clk_inv), .pin_data(pin_data), .pin_hs(pin_hs),
        .pin_vs(pin_vs), .pin_oe(pin_oe), .pin_clk(pin_clk)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // wait to the middle of the high phase after the next rising edge
    task automatic to_mid();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // then to the middle of the low phase
    task automatic to_late();
        @(negedge clk);
        #(CLK_PERIOD/4);
    endtask

    function automatic logic [23:0] exp_data(input logic [23:0] p, input int f, input int o, input bit act);
        int rb, rp, gb, gp, bb, bp;
        int ir, ig, ib, sr, sg, sb;
        ir = int'(p[23:16]); ig = int'(p[15:8]); ib = int'(p[7:0]);
        case (o)
            0: begin sr = ir; sg = ig; sb = ib; end
            1: begin sr = ib; sg = ig; sb = ir; end
            2: begin sr = ig; sg = ir; sb = ib; end
            default: begin sr = ib; sg = ir; sb = ig; end
        endcase
        case (f)
            1: begin rb = 5; rp = 11; gb = 6; gp = 5;  bb = 5; bp = 0; end
            2: begin rb = 5; rp = 16; gb = 6; gp = 8;  bb = 5; bp = 0; end
            3: begin rb = 5; rp = 17; gb = 6; gp = 8;  bb = 5; bp = 1; end
            4: begin rb = 6; rp = 12; gb = 6; gp = 6;  bb = 6; bp = 0; end
            5: begin rb = 6; rp = 16; gb = 6; gp = 8;  bb = 6; bp = 0; end
            6: begin rb = 8; rp = 16; gb = 8; gp = 8;  bb = 8; bp = 0; end
            default: return 24'h0;
        endcase
        if (!act) return 24'h0;
        return 24'(((sr >> (8 - rb)) << rp) | ((sg >> (8 - gb)) << gp) | ((sb >> (8 - bb)) << bp));
    endfunction

    function automatic string fmt_req(input int f);
        case (f)
            0, 7: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected<=%0d", cycles, WDOG_LIMIT);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] pats [6];
        pats[0] = 24'hFFFFFF; pats[1] = 24'h80_40_20; pats[2] = 24'hF8_FC_F8;
        pats[3] = 24'h07_03_07; pats[4] = 24'hA5_5A_C3; pats[5] = 24'h12_ED_9B;

        // R1: reset state, with output-enable inverted so its idle level is 1
        cfg_oe_inv = 1'b1; cfg_fmt = 3'd6; pix_in = 24'hFFFFFF;
        h_act = 1; v_act = 1; hs_in = 1; vs_in = 1;
        to_mid(); to_late(); to_mid(); to_late();
        chk(pin_data == 24'h0, "R1 data", 32'(pin_data), 0);
        chk(pin_hs == 1'b0,    "R1 hs",   32'(pin_hs), 0);
        chk(pin_vs == 1'b0,    "R1 vs",   32'(pin_vs), 0);
        chk(pin_oe == 1'b1,    "R1 oe",   32'(pin_oe), 1);
        rst = 1'b0; cfg_oe_inv = 1'b0;

        // R2..R8: format x order x pixel sweep, active region
        for (int f = 0; f < 8; f++) begin
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 6; k++) begin
                    cfg_fmt = 3'(f); cfg_order = 2'(o); pix_in = pats[k];
                    to_mid(); to_late();
                    chk(pin_data == exp_data(pats[k], f, o, 1'b1),
                        (o != 0) ? "R8" : fmt_req(f), 32'(pin_data), 32'(exp_data(pats[k], f, o, 1'b1)));
                end
            end
        end

        // R9: blanking forces zero data, in both output-enable modes
        cfg_fmt = 3'd6; cfg_order = 2'd0; pix_in = 24'hA5A5A5;
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 4; a++) begin
                cfg_oe_from_sync = m[0]; h_act = a[0]; v_act = a[1];
                to_mid(); to_late();
                chk(pin_data == ((a == 3) ? 24'hA5A5A5 : 24'h0), "R9",
                    32'(pin_data), (a == 3) ? 32'hA5A5A5 : 0);
            end
        end
        cfg_oe_from_sync = 0; h_act = 1; v_act = 1;

        // R10: one rising stage for data; falling launch lags by half a cycle
        cfg_ctl_off = 3'b000; cfg_fall_sel = 3'b001; hs_in = 0; vs_in = 0;
        pix_in = 24'h010203;
        to_mid(); to_late();
        hs_in = 1; vs_in = 1; pix_in = 24'h112233;
        chk(pin_data == 24'h010203, "R10 data before edge", 32'(pin_data), 32'h010203);
        to_mid();
        chk(pin_data == 24'h112233, "R10 data after edge", 32'(pin_data), 32'h112233);
        chk(pin_vs == 1'b1, "R10 rising vs", 32'(pin_vs), 1);
        chk(pin_hs == 1'b0, "R10 falling hs before negedge", 32'(pin_hs), 0);
        to_late();
        chk(pin_hs == 1'b1, "R10 falling hs after negedge", 32'(pin_hs), 1);
        hs_in = 0; vs_in = 0; cfg_fall_sel = 3'b100; h_act = 0;
        to_mid();
        chk(pin_oe == 1'b1, "R10 falling oe before negedge", 32'(pin_oe), 1);
        to_late();
        chk(pin_oe == 1'b0, "R10 falling oe after negedge", 32'(pin_oe), 0);

        // R11, R12, R13: every control configuration against every input pattern
        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < 16; p++) begin
                bit off_h, off_v, off_o, inv, msync, eh, ev, raw, eo;
                cfg_ctl_off = 3'(c); cfg_fall_sel = 3'(c >> 3);
                cfg_oe_inv = c[6]; cfg_oe_from_sync = c[7];
                cfg_clk_inv = c[0] ^ p[1];
                hs_in = p[0]; vs_in = p[1]; h_act = p[2]; v_act = p[3];
                off_h = c[0]; off_v = c[1]; off_o = c[2]; inv = c[6]; msync = c[7];
                eh  = off_h ? 1'b0 : p[0];
                ev  = off_v ? 1'b0 : p[1];
                raw = msync ? (p[0] | p[1]) : (p[2] & p[3]);
                eo  = off_o ? inv : (raw ^ inv);
                to_mid();
                chk(pin_clk == ~cfg_clk_inv, "R13 high", 32'(pin_clk), 32'(~cfg_clk_inv));
                to_late();
                chk(pin_clk == cfg_clk_inv, "R13 low", 32'(pin_clk), 32'(cfg_clk_inv));
                chk(pin_hs == eh, "R11 hs", 32'(pin_hs), 32'(eh));
                chk(pin_vs == ev, "R11 vs", 32'(pin_vs), 32'(ev));
                chk(pin_oe == eo, off_o ? "R11 oe" : "R12 oe", 32'(pin_oe), 32'(eo));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule